// File: doc/BRIEF.md
# Egress Fabric Cell Decapsulator

This block takes fixed-length cells from the egress side of a switch fabric and turns them into byte-wide CSIX frames. A receiver in front of it has already delineated the cells. Each cell arrives one byte per accepted cycle. A start strobe marks the first byte, and an error flag on that same byte marks a cell that the receiver dropped or that failed its BIP check.

The first eleven bytes of a cell form a switch header. The block unpacks that header into a backpressure record and presents the record for a single cycle for every good cell, whatever its type. The header type field selects which cells are forwarded: only unicast and multicast-ID cells pass. For those, the CSIX frame carried after the header is copied into an on-block byte FIFO with start-of-frame and end-of-frame marks. The frame's own payload-length byte decides how many bytes are copied, and the fabric pad that follows is discarded.

Before it copies anything, the block checks that the FIFO has room for the largest frame a cell can hold. If it does not, the frame is dropped and a one-cycle overflow pulse is raised. A downstream framer drains the FIFO through a show-ahead read port.

Top module: `ecd_egress_decap`

## Requirements
- R1: After reset, `rd_valid`, `bp_valid` and `fifo_overflow` are all low.
- R2: For each good cell, `bp_valid` is high for exactly one cycle. That cycle is the one after the cycle in which cell byte 10 is accepted. The record fields are laid out as follows, with cell byte 0 as the most significant byte of the first 11 bytes:
  - `bp_port` is byte 0 bits 6..3, and `bp_type` is byte 0 bits 2..0.
  - `bp_queues` holds bytes 1..8 high nibble as five 12-bit fields. Queue 1 sits in bits 59..48.
  - In `bp_qsel`/`bp_qon`, bit 4 belongs to queue 1 and bit 0 to queue 5. Queue 1 takes byte 8 bits 3/2, queue 2 byte 8 bits 1/0, queue 3 byte 9 bits 7/6, queue 4 byte 9 bits 5/4, and queue 5 byte 9 bits 3/2. In each pair, select is the higher bit and on is the lower bit.
  - `bp_mcast` is byte 9 bits 1..0, and `bp_diag` is byte 10.
- R3: The backpressure record is produced for good cells of every type, including the types that are discarded.
- R4: Only cells whose `bp_type` equals `UCAST_CODE` (default 3'd1) or `MCAST_CODE` (default 3'd2) write anything into the FIFO.
- R5: For a forwarded cell, the FIFO receives cell bytes 11 onward, in order, for min(L + EXT_BYTES + 4, PAYLOAD_BYTES) bytes, where L is cell byte 12. The remaining bytes of the cell are not written.
- R6: The first byte written for a frame carries `rd_sop`, and the last byte written carries `rd_eop`.
- R7: A cell whose start byte has `cell_bad` high produces no record and no FIFO write.
- R8: A forwardable cell is dropped if, when its start byte is accepted, the FIFO's free space is less than PAYLOAD_BYTES. In that case `fifo_overflow` pulses for one cycle, in the cycle after the start byte, and no byte of that cell is written.
- R9: The read port is show-ahead. `rd_byte`, `rd_sop` and `rd_eop` show the oldest word while `rd_valid` is high, and a cycle with `rd_en` high removes that word. Writes and reads may occur in the same cycle.
- R10: Cycles with `cell_valid` low are ignored, so gaps inside a cell do not shift byte positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_valid | input | 1 | A cell byte is present this cycle |
| cell_start | input | 1 | Marks the first byte of a cell |
| cell_bad | input | 1 | Drop/BIP error flag, taken with the start byte |
| cell_byte | input | 8 | Cell byte |
| bp_valid | output | 1 | Backpressure record strobe |
| bp_port | output | 4 | Port backpressure field |
| bp_type | output | 3 | Cell type field |
| bp_queues | output | 60 | Five 12-bit queue backpressure fields, queue 1 on top |
| bp_qsel | output | 5 | Per-queue select bits, queue 1 in bit 4 |
| bp_qon | output | 5 | Per-queue on bits, queue 1 in bit 4 |
| bp_mcast | output | 2 | Multicast backpressure field |
| bp_diag | output | 8 | Diagnostic byte |
| fifo_overflow | output | 1 | Pulse: a frame was dropped for lack of room |
| rd_en | input | 1 | Pop the FIFO head |
| rd_valid | output | 1 | FIFO not empty |
| rd_byte | output | 8 | FIFO head byte |
| rd_sop | output | 1 | Head byte starts a frame |
| rd_eop | output | 1 | Head byte ends a frame |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the FIFO push and the downstream pop. The bench keeps its reader draining while cells stream in, so a write and a read fall together on most cycles. It judges the result by comparing every popped word, marks included, against a model queue.

The second pair is the room check on a start byte and the emission of a record or overflow pulse. With the reader stopped, the bench fills the FIFO to the exact boundary. It then expects one more frame to be accepted at exactly PAYLOAD_BYTES free and the next to overflow. A discarded-type cell sent while the FIFO is full must still produce its record and must raise no overflow.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    localparam int HDR_BYTES = 11;
    localparam int NQUEUES   = 5;
    localparam int QBITS     = 12;

    typedef struct packed {
        logic [3:0]               port;
        logic [2:0]               ctype;
        logic [NQUEUES*QBITS-1:0] queues;
        logic [NQUEUES-1:0]       qsel;
        logic [NQUEUES-1:0]       qon;
        logic [1:0]               mcast;
        logic [7:0]               diag;
    } bp_rec_t;

    typedef struct packed {
        logic       sop;
        logic       eop;
        logic [7:0] data;
    } fifo_word_t;

    // Unpack the 88-bit header (byte 0 at the top) into a record.
    function automatic bp_rec_t unpack_hdr(input logic [8*HDR_BYTES-1:0] h);
        bp_rec_t r;
        r.port   = h[86:83];
        r.ctype  = h[82:80];
        r.queues = h[79:20];
        for (int q = 0; q < NQUEUES; q++) begin
            r.qsel[NQUEUES-1-q] = h[19-2*q];
            r.qon[NQUEUES-1-q]  = h[18-2*q];
        end
        r.mcast  = h[9:8];
        r.diag   = h[7:0];
        return r;
    endfunction

    // Bytes of the inner frame to keep: headers + payload + parity, capped.
    function automatic logic [8:0] frame_extent(input logic [7:0] plen,
                                                input int ext, input int cap);
        int sum;
        sum = int'(plen) + ext + 4;
        if (sum > cap) sum = cap;
        return 9'(sum);
    endfunction

endpackage

// File: rtl/ecd_hdr_parse.sv
module ecd_hdr_parse
    import ecd_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_en,
    input  logic [IW-1:0] byte_idx,
    input  logic [7:0]    byte_in,
    output logic          rec_valid,
    output bp_rec_t       rec
);
    localparam int SRW = 8 * (HDR_BYTES - 1);

    logic [SRW-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            rec_valid <= 1'b0;
            rec       <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (byte_en) begin
                if (byte_idx < IW'(HDR_BYTES - 1)) begin
                    shreg <= {shreg[SRW-9:0], byte_in};
                end else if (byte_idx == IW'(HDR_BYTES - 1)) begin
                    rec_valid <= 1'b1;
                    rec       <= unpack_hdr({shreg, byte_in});
                end
            end
        end
    end
endmodule

// File: rtl/ecd_cell_seq.sv
module ecd_cell_seq
    import ecd_pkg::*;
#(
    parameter int         CELL_BYTES    = 75,
    parameter int         PAYLOAD_BYTES = 64,
    parameter int         EXT_BYTES     = 4,
    parameter logic [2:0] UCAST_CODE    = 3'd1,
    parameter logic [2:0] MCAST_CODE    = 3'd2,
    parameter int         CW            = 13,
    parameter int         IW            = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic          in_bad,
    input  logic [7:0]    in_byte,
    input  logic [CW-1:0] fifo_free,
    output logic          hdr_en,
    output logic [IW-1:0] cur_idx,
    output logic [2:0]    cell_type,
    output logic          wr_en,
    output fifo_word_t    wr_word,
    output logic          overflow
);
    logic          active, cbad, fwd;
    logic [IW-1:0] idx;
    logic [8:0]    total;
    logic          accept, type_ok, room, in_frame_zone;
    logic [8:0]    off;

    assign accept        = in_valid && (in_start || active);
    assign cur_idx       = in_start ? '0 : idx;
    assign type_ok       = (in_byte[2:0] == UCAST_CODE) || (in_byte[2:0] == MCAST_CODE);
    assign room          = fifo_free >= CW'(PAYLOAD_BYTES);
    assign hdr_en        = accept && !(in_start ? in_bad : cbad) && (cur_idx < IW'(HDR_BYTES));
    assign in_frame_zone = !in_start && (idx >= IW'(HDR_BYTES));
    assign off           = 9'(idx) - 9'(HDR_BYTES);

    always_comb begin
        wr_en        = 1'b0;
        wr_word.sop  = 1'b0;
        wr_word.eop  = 1'b0;
        wr_word.data = in_byte;
        if (accept && fwd && in_frame_zone) begin
            if (off < 9'd2) begin
                wr_en       = 1'b1;
                wr_word.sop = (off == 9'd0);
            end else if (off < total) begin
                wr_en       = 1'b1;
                wr_word.eop = (off == total - 9'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cbad      <= 1'b0;
            fwd       <= 1'b0;
            idx       <= '0;
            total     <= '0;
            cell_type <= '0;
            overflow  <= 1'b0;
        end else begin
            overflow <= 1'b0;
            if (accept) begin
                if (in_start) begin
                    active    <= 1'b1;
                    idx       <= IW'(1);
                    cbad      <= in_bad;
                    cell_type <= in_byte[2:0];
                    fwd       <= !in_bad && type_ok && room;
                    overflow  <= !in_bad && type_ok && !room;
                end else begin
                    idx <= idx + IW'(1);
                    if (idx == IW'(CELL_BYTES - 1)) active <= 1'b0;
                    if (idx == IW'(HDR_BYTES + 1))
                        total <= frame_extent(in_byte, EXT_BYTES, PAYLOAD_BYTES);
                end
            end
        end
    end
endmodule

// File: rtl/ecd_fifo.sv
module ecd_fifo
    import ecd_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int CW    = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  fifo_word_t    wr_word,
    input  logic          rd_en,
    output fifo_word_t    rd_word,
    output logic          rd_valid,
    output logic [CW-1:0] count,
    output logic [CW-1:0] free
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_word_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_rd;

    assign rd_valid = count != '0;
    assign do_rd    = rd_en && rd_valid;
    assign rd_word  = mem[rptr];
    assign free     = CW'(DEPTH) - count;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            case ({wr_en, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ecd_egress_decap.sv
module ecd_egress_decap
    import ecd_pkg::*;
#(
    parameter int         PAYLOAD_BYTES = 64,
    parameter int         EXT_BYTES     = 4,
    parameter int         FIFO_DEPTH    = 4096,
    parameter logic [2:0] UCAST_CODE    = 3'd1,
    parameter logic [2:0] MCAST_CODE    = 3'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cell_valid,
    input  logic        cell_start,
    input  logic        cell_bad,
    input  logic [7:0]  cell_byte,
    output logic        bp_valid,
    output logic [3:0]  bp_port,
    output logic [2:0]  bp_type,
    output logic [59:0] bp_queues,
    output logic [4:0]  bp_qsel,
    output logic [4:0]  bp_qon,
    output logic [1:0]  bp_mcast,
    output logic [7:0]  bp_diag,
    output logic        fifo_overflow,
    input  logic        rd_en,
    output logic        rd_valid,
    output logic [7:0]  rd_byte,
    output logic        rd_sop,
    output logic        rd_eop
);
    localparam int CELL_BYTES = HDR_BYTES + PAYLOAD_BYTES;
    localparam int IW         = $clog2(CELL_BYTES + 1);
    localparam int CW         = $clog2(FIFO_DEPTH + 1);

    logic          hdr_en, wr_en;
    logic [IW-1:0] cur_idx;
    logic [2:0]    cell_type;
    fifo_word_t    wr_word, rd_word;
    logic [CW-1:0] fifo_count, fifo_free;
    bp_rec_t       rec;

    ecd_cell_seq #(
        .CELL_BYTES(CELL_BYTES), .PAYLOAD_BYTES(PAYLOAD_BYTES), .EXT_BYTES(EXT_BYTES),
        .UCAST_CODE(UCAST_CODE), .MCAST_CODE(MCAST_CODE), .CW(CW), .IW(IW)
    ) u_seq (
        .clk(clk), .rst(rst), .in_valid(cell_valid), .in_start(cell_start),
        .in_bad(cell_bad), .in_byte(cell_byte), .fifo_free(fifo_free),
        .hdr_en(hdr_en), .cur_idx(cur_idx), .cell_type(cell_type),
        .wr_en(wr_en), .wr_word(wr_word), .overflow(fifo_overflow)
    );

    ecd_hdr_parse #(.IW(IW)) u_hdr (
        .clk(clk), .rst(rst), .byte_en(hdr_en), .byte_idx(cur_idx),
        .byte_in(cell_byte), .rec_valid(bp_valid), .rec(rec)
    );

    ecd_fifo #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .rd_word(rd_word), .rd_valid(rd_valid),
        .count(fifo_count), .free(fifo_free)
    );

    assign bp_port   = rec.port;
    assign bp_type   = rec.ctype;
    assign bp_queues = rec.queues;
    assign bp_qsel   = rec.qsel;
    assign bp_qon    = rec.qon;
    assign bp_mcast  = rec.mcast;
    assign bp_diag   = rec.diag;
    assign rd_byte   = rd_word.data;
    assign rd_sop    = rd_word.sop;
    assign rd_eop    = rd_word.eop;
endmodule

// File: rtl/ecd_checker.sv
module ecd_checker #(
    parameter int         DEPTH      = 4096,
    parameter int         CW         = 13,
    parameter logic [2:0] UCAST_CODE = 3'd1,
    parameter logic [2:0] MCAST_CODE = 3'd2
) (
    input logic          clk,
    input logic          rst,
    input logic          cell_valid,
    input logic          cell_start,
    input logic          cell_bad,
    input logic          bp_valid,
    input logic          fifo_overflow,
    input logic          wr_en,
    input logic          wr_sop,
    input logic          wr_eop,
    input logic [2:0]    cell_type,
    input logic [CW-1:0] fifo_count,
    input logic          rd_en,
    input logic          rd_valid
);
    logic in_frame;

    always_ff @(posedge clk) begin
        if (rst)        in_frame <= 1'b0;
        else if (wr_en) in_frame <= !wr_eop;
    end

    assert_bp_single_R2: assert property (@(posedge clk) disable iff (rst)
        bp_valid |=> !bp_valid);

    assert_frame_marks_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_sop == !in_frame));

    assert_type_filter_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (cell_type == UCAST_CODE || cell_type == MCAST_CODE));

    assert_ovf_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_overflow |-> !wr_en);

    assert_bad_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (cell_valid && cell_start && cell_bad) |=> !fifo_overflow);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_valid && !wr_en) |=> (fifo_count == $past(fifo_count)));
endmodule

bind ecd_egress_decap ecd_checker #(
    .DEPTH(FIFO_DEPTH), .CW(CW), .UCAST_CODE(UCAST_CODE), .MCAST_CODE(MCAST_CODE)
) u_chk (
    .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_start(cell_start),
    .cell_bad(cell_bad), .bp_valid(bp_valid), .fifo_overflow(fifo_overflow),
    .wr_en(wr_en), .wr_sop(wr_word.sop), .wr_eop(wr_word.eop),
    .cell_type(cell_type), .fifo_count(fifo_count), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/test_ecd_egress_decap.sv
`timescale 1ns/1ps
module test_ecd_egress_decap;
    localparam int P     = 16;
    localparam int EXT   = 4;
    localparam int DEPTH = 64;
    localparam int CELL  = 11 + P;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cell_valid = 1'b0, cell_start = 1'b0, cell_bad = 1'b0;
    logic [7:0]  cell_byte = '0;
    logic        bp_valid;
    logic [3:0]  bp_port;
    logic [2:0]  bp_type;
    logic [59:0] bp_queues;
    logic [4:0]  bp_qsel, bp_qon;
    logic [1:0]  bp_mcast;
    logic [7:0]  bp_diag;
    logic        fifo_overflow;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        rd_sop, rd_eop;

    int checks = 0;
    int fails  = 0;
    bit rd_on  = 1'b0;

    logic [9:0]  exp_words [$];
    logic [86:0] exp_recs  [$];

    always #5 clk = ~clk;

    ecd_egress_decap #(
        .PAYLOAD_BYTES(P), .EXT_BYTES(EXT), .FIFO_DEPTH(DEPTH),
        .UCAST_CODE(3'd1), .MCAST_CODE(3'd2)
    ) i_ecd_egress_decap (
        .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_start(cell_start),
        .cell_bad(cell_bad), .cell_byte(cell_byte), .bp_valid(bp_valid),
        .bp_port(bp_port), .bp_type(bp_type), .bp_queues(bp_queues),
        .bp_qsel(bp_qsel), .bp_qon(bp_qon), .bp_mcast(bp_mcast), .bp_diag(bp_diag),
        .fifo_overflow(fifo_overflow), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_byte(rd_byte), .rd_sop(rd_sop), .rd_eop(rd_eop)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Record monitor (R2, R3)
    always @(negedge clk) begin
        if (!rst && bp_valid) begin
            logic [86:0] got;
            got = {bp_port, bp_type, bp_queues, bp_qsel, bp_qon, bp_mcast, bp_diag};
            if (exp_recs.size() == 0)
                check(1'b0, "R2", "unexpected record", 128'(got), 128'(0));
            else begin
                logic [86:0] e;
                e = exp_recs.pop_front();
                check(got == e, "R2/R3", "record fields", 128'(got), 128'(e));
            end
        end
    end

    // Reader (R5, R6, R9)
    always @(negedge clk) begin
        rd_en <= 1'b0;
        if (!rst && rd_on && rd_valid) begin
            logic [9:0] got;
            got = {rd_sop, rd_eop, rd_byte};
            if (exp_words.size() == 0)
                check(1'b0, "R4/R5", "unexpected fifo word", 128'(got), 128'(0));
            else begin
                logic [9:0] e;
                e = exp_words.pop_front();
                check(got == e, "R5/R6", "fifo word", 128'(got), 128'(e));
            end
            rd_en <= 1'b1;
        end
    end

    task automatic send_cell(input logic [2:0] ctype, input logic [7:0] plen,
                             input bit bad, input bit gaps, input logic [7:0] seed);
        logic [7:0]  cb [CELL];
        logic [87:0] h;
        bit          fwd, room;
        int          total;
        cb[0] = {1'b0, seed[3:0], ctype};
        for (int i = 1; i < 11; i++) cb[i] = 8'((seed * 37 + i * 13) ^ 8'h5A);
        cb[11] = 8'h40 | seed;
        cb[12] = plen;
        for (int i = 13; i < CELL; i++) cb[i] = 8'(seed + i * 7);
        for (int i = 0; i < 11; i++) h[87-8*i -: 8] = cb[i];
        if (!bad)
            exp_recs.push_back({h[86:83], h[82:80], h[79:20],
                                h[19], h[17], h[15], h[13], h[11],
                                h[18], h[16], h[14], h[12], h[10],
                                h[9:8], h[7:0]});
        fwd  = !bad && (ctype == 3'd1 || ctype == 3'd2);
        room = (DEPTH - exp_words.size()) >= P;
        total = int'(plen) + EXT + 4;
        if (total > P) total = P;
        if (fwd && room)
            for (int o = 0; o < total; o++)
                exp_words.push_back({o == 0, o == total - 1, cb[11 + o]});
        for (int i = 0; i < CELL; i++) begin
            if (gaps && i > 12 && (i % 3) == 0) begin
                cell_valid = 1'b0;
                @(negedge clk);
            end
            if (i == 1)
                check(fifo_overflow == (fwd && !room), "R8", "overflow pulse",
                      128'(fifo_overflow), 128'(fwd && !room));
            cell_valid = 1'b1;
            cell_start = (i == 0);
            cell_bad   = (i == 0) ? bad : 1'b0;
            cell_byte  = cb[i];
            @(negedge clk);
        end
        cell_valid = 1'b0;
        cell_start = 1'b0;
        cell_byte  = 8'hEE;
    endtask

    task automatic drain();
        int guard = 0;
        rd_on = 1'b1;
        while ((exp_words.size() != 0 || rd_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(exp_words.size() == 0, "R9", "model queue drained",
              128'(exp_words.size()), 128'(0));
        check(!rd_valid, "R9", "fifo empty after drain", 128'(rd_valid), 128'(0));
        check(exp_recs.size() == 0, "R3", "all records seen",
              128'(exp_recs.size()), 128'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] lens [5];
        lens = '{8'd0, 8'd3, 8'd8, 8'd9, 8'd200};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(!rd_valid, "R1", "rd_valid after reset", 128'(rd_valid), 128'(0));
        check(!bp_valid, "R1", "bp_valid after reset", 128'(bp_valid), 128'(0));
        check(!fifo_overflow, "R1", "overflow after reset", 128'(fifo_overflow), 128'(0));

        // R3/R4/R5/R10: every type, several lengths, with and without gaps
        rd_on = 1'b1;
        for (int t = 0; t < 8; t++)
            for (int l = 0; l < 5; l++)
                send_cell(3'(t), lens[l], 1'b0, (l % 2) == 1, 8'(t * 5 + l));
        // R7: bad cells of forwardable types produce nothing
        send_cell(3'd1, 8'd4, 1'b1, 1'b0, 8'h21);
        send_cell(3'd2, 8'd2, 1'b1, 1'b1, 8'h22);
        send_cell(3'd1, 8'd1, 1'b0, 1'b0, 8'h23);
        drain();

        // R8: fill to the boundary with the reader stopped
        rd_on = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) send_cell(3'd1, 8'd8, 1'b0, 1'b0, 8'(8'h30 + k));
        send_cell(3'd2, 8'd0, 1'b0, 1'b0, 8'h35);   // no room: overflow
        send_cell(3'd5, 8'd0, 1'b0, 1'b0, 8'h36);   // discarded type: record only
        send_cell(3'd1, 8'd2, 1'b1, 1'b0, 8'h37);   // bad: nothing
        check(rd_valid, "R9", "fifo holds data while reader stopped", 128'(rd_valid), 128'(1));
        drain();
        // R8: after drain, room again
        send_cell(3'd2, 8'd3, 1'b0, 1'b1, 8'h38);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule